// File: doc/BRIEF.md
# Segmented Content-Addressed Line Cache

This block is a 4 KB read cache for a 32-bit processor. Lines are four 32-bit words. The cache is split into four segments, and each segment is fully associative over its lines. An access runs in three steps. Two low address bits pick the segment. The remaining upper address bits are then compared in parallel against every tag entry of that segment, as in a content-addressable memory. Only when exactly one entry matches is the data array read or written, at the row that entry selects.

The processor issues one request at a time. Each request carries an address, a write flag, byte enables and write data. Every accepted request gets one response pulse, which reports whether the access hit.

On a read miss the block picks a victim way in the segment with a round-robin pointer kept per segment. It then asks a memory model for the four words of the line, writes them in order and completes the read. Writes are write-through with no allocation: a write that hits merges the enabled bytes into the cached word, and a write that misses only acknowledges. A synchronous invalidate-all input empties the cache in one cycle.

Top module: `seg_cam_cache`

## Requirements
- R1: After reset, every entry is invalid, `req_ready` is 1, and `rsp_valid` and `fill_req` are 0. The first read of any address misses.
- R2: Address bits [5:4] choose the segment and bits [31:6] form the tag. Lines that share bits [31:6] but differ in bits [5:4] are held and filled independently.
- R3: Address bits [3:2] choose the word of the line that a read returns or a write updates.
- R4: A read that hits gives `rsp_valid`=1 and `rsp_hit`=1 with the addressed word on `rsp_rdata` in the cycle after the request is accepted.
- R5: A read that misses raises `fill_req`, with `fill_addr` equal to the request address with bits [3:0] cleared. The block takes four words on `fill_valid`, word 0 first. In the cycle after the fourth word it gives `rsp_valid`=1 and `rsp_hit`=0, with the requested word on `rsp_rdata`. After that the line hits.
- R6: Each segment has its own allocation pointer, which starts at way 0 and advances by one, wrapping, on each read miss in that segment. The n-th fill of a segment replaces way n mod WAYS. Fills in one segment never evict lines of another segment.
- R7: A write that hits stores only the bytes whose `req_be` bit is set (bit i covers data bits [8i+7:8i]) and responds with `rsp_hit`=1 one cycle after acceptance.
- R8: A write that misses responds with `rsp_valid`=1 and `rsp_hit`=0 one cycle after acceptance. It raises no fill and allocates no line.
- R9: `inv_all` clears every valid bit in one cycle, and `req_ready` is 0 while it is high. Every line misses afterwards.
- R10: Within a segment at most one valid entry ever matches a given tag, so the match vector is one-hot or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Invalidate every line this cycle |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Access hit the cache |
| rsp_rdata | output | 32 | Read data |
| fill_req | output | 1 | Line fill requested, held until the fourth word |
| fill_addr | output | 32 | Line address of the fill |
| fill_valid | input | 1 | Fill word present |
| fill_data | input | 32 | Fill word, in word order |

## Verification
The bench builds the cache with WAYS=4 and keeps the fixed four-segment, four-word-line layout. Five distinct tags then wrap a segment's round-robin pointer after a few fills, so the bench can reach eviction, re-allocation of an evicted tag and the check that other segments are left untouched. The bench also steers line fills, byte-merged write hits, non-allocating write misses and invalidate-all through a per-response scoreboard. That scoreboard also measures the one-cycle hit latency.

// File: rtl/cam_cache_pkg.sv
package cam_cache_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int BE_W       = DATA_W / 8;
  localparam int LINE_WORDS = 4;
  localparam int SEGS       = 4;
  localparam int BYTE_OFF_W = $clog2(BE_W);
  localparam int WORD_SEL_W = $clog2(LINE_WORDS);
  localparam int SEG_W      = $clog2(SEGS);
  localparam int LINE_OFF_W = BYTE_OFF_W + WORD_SEL_W;
  localparam int TAG_W      = ADDR_W - LINE_OFF_W - SEG_W;

  typedef logic [TAG_W-1:0]      tag_t;
  typedef logic [SEG_W-1:0]      seg_t;
  typedef logic [WORD_SEL_W-1:0] wsel_t;
  typedef logic [DATA_W-1:0]     word_t;

  function automatic seg_t seg_of(input logic [ADDR_W-1:0] a);
    return a[LINE_OFF_W +: SEG_W];
  endfunction

  function automatic tag_t tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic wsel_t word_of(input logic [ADDR_W-1:0] a);
    return a[BYTE_OFF_W +: WORD_SEL_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_addr(input tag_t t, input seg_t s);
    return {t, s, {LINE_OFF_W{1'b0}}};
  endfunction
endpackage

// File: rtl/cam_tag_store.sv
module cam_tag_store import cam_cache_pkg::*; #(
  parameter int WAYS  = 64,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  seg_t             lk_seg,
  input  tag_t             lk_tag,
  output logic [WAYS-1:0]  match_vec,
  input  logic             wr_en,
  input  seg_t             wr_seg,
  input  logic [WAY_W-1:0] wr_way,
  input  tag_t             wr_tag,
  output logic             any_valid
);
  logic [SEGS-1:0][WAYS-1:0] vld_q;
  tag_t                      tag_q [SEGS][WAYS];

  // Valid bits: invalidate-all has priority over a fill completing.
  always_ff @(posedge clk) begin
    if (!rst_n)       vld_q <= '0;
    else if (clr_all) vld_q <= '0;
    else if (wr_en)   vld_q[wr_seg][wr_way] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_seg][wr_way] <= wr_tag;
  end

  // Parallel compare across every entry of the selected segment.
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_vec[w] = vld_q[lk_seg][w] && (tag_q[lk_seg][w] == lk_tag);
  end

  assign any_valid = |vld_q;
endmodule

// File: rtl/line_data_ram.sv
module line_data_ram import cam_cache_pkg::*; #(
  parameter int WAYS  = 64,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  seg_t             rd_seg,
  input  logic [WAY_W-1:0] rd_way,
  input  wsel_t            rd_word,
  output word_t            rd_data,
  input  logic             wr_en,
  input  seg_t             wr_seg,
  input  logic [WAY_W-1:0] wr_way,
  input  wsel_t            wr_word,
  input  logic [BE_W-1:0]  wr_be,
  input  word_t            wr_data
);
  localparam int DEPTH = SEGS * WAYS * LINE_WORDS;
  localparam int AW    = SEG_W + WAY_W + WORD_SEL_W;

  word_t mem_q [DEPTH];
  word_t rd_q;

  // Segments, ways and words are powers of two, so the row is a concatenation.
  function automatic logic [AW-1:0] row_of(input seg_t s, input logic [WAY_W-1:0] w,
                                           input wsel_t k);
    return {s, w, k};
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be[b]) mem_q[row_of(wr_seg, wr_way, wr_word)][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
    if (rd_en) rd_q <= mem_q[row_of(rd_seg, rd_way, rd_word)];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/victim_rr.sv
module victim_rr import cam_cache_pkg::*; #(
  parameter int WAYS  = 64,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seg_t             seg,
  input  logic             advance,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] ptr_q [SEGS];

  for (genvar s = 0; s < SEGS; s++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n)                           ptr_q[s] <= '0;
      else if (advance && seg == seg_t'(s)) ptr_q[s] <= ptr_q[s] + 1'b1;
    end
  end

  assign victim = ptr_q[seg];
endmodule

// File: rtl/seg_cam_cache.sv
module seg_cam_cache import cam_cache_pkg::*; #(
  parameter int WAYS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int    WAY_W     = $clog2(WAYS);
  localparam wsel_t LAST_WORD = wsel_t'(LINE_WORDS - 1);

  typedef enum logic {ST_IDLE, ST_FILL} st_e;

  function automatic logic [WAY_W-1:0] onehot_idx(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (v[i]) r = r | WAY_W'(i);
    end
    return r;
  endfunction

  st_e              st_q;
  seg_t             req_seg;
  tag_t             req_tag;
  wsel_t            req_word;
  logic [WAYS-1:0]  match_vec;
  logic             lookup_hit, any_valid, req_fire;
  logic             rd_miss, wr_hit, fill_beat, fill_done;
  logic [WAY_W-1:0] hit_way, rr_victim;
  tag_t             miss_tag_q;
  seg_t             miss_seg_q;
  wsel_t            miss_word_q, fill_cnt_q;
  logic [WAY_W-1:0] victim_q;
  word_t            fill_cap_q, ram_rd;
  logic             rsp_valid_q, rsp_hit_q, from_fill_q;
  logic             ram_we;
  seg_t             ram_wseg;
  logic [WAY_W-1:0] ram_wway;
  wsel_t            ram_wword;
  logic [BE_W-1:0]  ram_wbe;
  word_t            ram_wdata;
  logic             unused_byte_off;

  // Address decode: segment first, then tag compare, then word select.
  assign req_seg         = seg_of(req_addr);
  assign req_tag         = tag_of(req_addr);
  assign req_word        = word_of(req_addr);
  assign unused_byte_off = ^req_addr[BYTE_OFF_W-1:0];

  assign req_ready  = (st_q == ST_IDLE) && !inv_all;
  assign req_fire   = req_valid && req_ready;
  assign lookup_hit = |match_vec;
  assign hit_way    = onehot_idx(match_vec);
  assign rd_miss    = req_fire && !req_we && !lookup_hit;
  assign wr_hit     = req_fire && req_we && lookup_hit;
  assign fill_beat  = (st_q == ST_FILL) && fill_valid;
  assign fill_done  = fill_beat && (fill_cnt_q == LAST_WORD);

  cam_tag_store #(.WAYS(WAYS), .WAY_W(WAY_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .clr_all(inv_all),
    .lk_seg(req_seg), .lk_tag(req_tag), .match_vec(match_vec),
    .wr_en(fill_done), .wr_seg(miss_seg_q), .wr_way(victim_q), .wr_tag(miss_tag_q),
    .any_valid(any_valid)
  );

  victim_rr #(.WAYS(WAYS), .WAY_W(WAY_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .seg(req_seg), .advance(rd_miss), .victim(rr_victim)
  );

  // Data array write port: fill beats in the fill state, byte-merged hits otherwise.
  always_comb begin
    if (st_q == ST_FILL) begin
      ram_we    = fill_valid;
      ram_wseg  = miss_seg_q;
      ram_wway  = victim_q;
      ram_wword = fill_cnt_q;
      ram_wbe   = '1;
      ram_wdata = fill_data;
    end else begin
      ram_we    = wr_hit;
      ram_wseg  = req_seg;
      ram_wway  = hit_way;
      ram_wword = req_word;
      ram_wbe   = req_be;
      ram_wdata = req_wdata;
    end
  end

  line_data_ram #(.WAYS(WAYS), .WAY_W(WAY_W)) u_data (
    .clk(clk),
    .rd_en(req_fire && !req_we && lookup_hit), .rd_seg(req_seg), .rd_way(hit_way),
    .rd_word(req_word), .rd_data(ram_rd),
    .wr_en(ram_we), .wr_seg(ram_wseg), .wr_way(ram_wway), .wr_word(ram_wword),
    .wr_be(ram_wbe), .wr_data(ram_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      from_fill_q <= 1'b0;
      fill_cnt_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_fire) begin
            if (lookup_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_hit_q   <= 1'b1;
              from_fill_q <= 1'b0;
            end else if (req_we) begin
              rsp_valid_q <= 1'b1;
            end else begin
              st_q       <= ST_FILL;
              fill_cnt_q <= '0;
            end
          end
        end
        ST_FILL: begin
          if (fill_beat) fill_cnt_q <= fill_cnt_q + 1'b1;
          if (fill_done) begin
            st_q        <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            from_fill_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rd_miss) begin
      miss_tag_q  <= req_tag;
      miss_seg_q  <= req_seg;
      miss_word_q <= req_word;
      victim_q    <= rr_victim;
    end
    if (fill_beat && fill_cnt_q == miss_word_q) fill_cap_q <= fill_data;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_rdata = from_fill_q ? fill_cap_q : ram_rd;
  assign fill_req  = (st_q == ST_FILL);
  assign fill_addr = line_addr(miss_tag_q, miss_seg_q);
endmodule

// File: rtl/seg_cam_cache_chk.sv
module seg_cam_cache_chk #(
  parameter int WAYS = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            inv_all,
  input logic            req_fire,
  input logic            req_we,
  input logic            lookup_hit,
  input logic [WAYS-1:0] match_vec,
  input logic            any_valid,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            fill_req
);
  // R10: the compare never finds two valid entries holding one tag
  a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R4: read hit answers in the next cycle with the hit flag
  a_r4_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !req_we && lookup_hit |=> rsp_valid && rsp_hit);

  // R5: read miss starts a fill instead of answering
  a_r5_miss_fills: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !req_we && !lookup_hit |=> fill_req && !rsp_valid);

  // R5: the hit flag is only ever part of a response
  a_r5_hit_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  // R8: write miss acknowledges at once without a fill
  a_r8_write_miss_ack: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && req_we && !lookup_hit |=> rsp_valid && !rsp_hit && !fill_req);

  // R9: invalidate-all leaves no valid entry
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !any_valid);
endmodule

bind seg_cam_cache seg_cam_cache_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .req_fire(req_fire), .req_we(req_we),
  .lookup_hit(lookup_hit), .match_vec(match_vec), .any_valid(any_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .fill_req(fill_req)
);

// File: tb/tb_seg_cam_cache.sv
module tb_seg_cam_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inv_all = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_rdata;
  logic        fill_req;
  logic [31:0] fill_addr;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_data = '0;

  int n_chk = 0, n_bad = 0, cyc = 0, fill_count = 0;
  logic [31:0] exp_fill_addr = '0;

  // Scoreboard queues, one item per expected response
  bit          q_hit[$];
  bit          q_cmp_data[$];
  logic [31:0] q_data[$];
  int          q_issue[$];
  string       q_req[$];

  always #4 clk = ~clk;

  seg_cam_cache #(.WAYS(4)) dut (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h0001_0003) ^ 32'hC3C3_0000;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // Memory model answering line fills, word 0 first
  initial begin
    forever begin
      @(negedge clk);
      if (fill_req) begin
        check(fill_addr == exp_fill_addr, "R5", "fill_addr", fill_addr, exp_fill_addr);
        fill_count++;
        for (int k = 0; k < 4; k++) begin
          fill_valid = 1'b1;
          fill_data  = mem_word(fill_addr + 32'(k * 4));
          @(negedge clk);
        end
        fill_valid = 1'b0;
      end
    end
  end

  // Monitor: pop and compare each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_hit.size() == 0) begin
        check(1'b0, "R4", "unexpected response", 32'd1, 32'd0);
      end else begin
        automatic bit          eh = q_hit.pop_front();
        automatic bit          ec = q_cmp_data.pop_front();
        automatic logic [31:0] ed = q_data.pop_front();
        automatic int          ei = q_issue.pop_front();
        automatic string       er = q_req.pop_front();
        check(rsp_hit == eh, er, "rsp_hit", 32'(rsp_hit), 32'(eh));
        if (ec) check(rsp_rdata == ed, er, "rsp_rdata", rsp_rdata, ed);
        if (eh) check(cyc - ei == 1, er, "hit latency", 32'(cyc - ei), 32'd1);
      end
    end
  end

  task automatic issue(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                       input logic [3:0] be, input bit eh, input bit ec,
                       input logic [31:0] ed, input string req);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_fill_addr = {addr[31:4], 4'h0};
    q_hit.push_back(eh);
    q_cmp_data.push_back(ec);
    q_data.push_back(ed);
    q_issue.push_back(cyc);
    q_req.push_back(req);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = addr;
    req_wdata = wd;
    req_be    = be;
    @(negedge clk);
    req_valid = 1'b0;
    req_we    = 1'b0;
    while (q_hit.size() != 0) @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] addr, input bit eh, input string req);
    issue(1'b0, addr, '0, '0, eh, 1'b1, mem_word(addr), req);
  endtask

  initial begin
    int fc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    check(fill_req == 1'b0, "R1", "fill_req", 32'(fill_req), 32'd0);

    rd(32'h0000_1008, 1'b0, "R1 R5 first read misses and fills");
    rd(32'h0000_1008, 1'b1, "R4 read hit");
    rd(32'h0000_100C, 1'b1, "R3 word 3");
    rd(32'h0000_1000, 1'b1, "R3 word 0");
    rd(32'h0000_1018, 1'b0, "R2 other segment misses");
    rd(32'h0000_1008, 1'b1, "R2 segment 0 line kept");

    issue(1'b1, 32'h0000_1004, 32'hDEAD_BEEF, 4'b0101, 1'b1, 1'b0, '0, "R7 write hit");
    issue(1'b0, 32'h0000_1004, '0, '0, 1'b1, 1'b1,
          merge(mem_word(32'h0000_1004), 32'hDEAD_BEEF, 4'b0101), "R7 byte merge");

    fc = fill_count;
    issue(1'b1, 32'h0000_2000, 32'h1234_5678, 4'b1111, 1'b0, 1'b0, '0, "R8 write miss");
    check(fill_count == fc, "R8", "fills after write miss", 32'(fill_count), 32'(fc));
    rd(32'h0000_2000, 1'b0, "R8 no allocation");

    // R6: segment 0 pointer is at way 2 now; fill ways 2,3 then wrap to way 0
    rd(32'h0000_3000, 1'b0, "R6 fill way 2");
    rd(32'h0000_4000, 1'b0, "R6 fill way 3");
    rd(32'h0000_5000, 1'b0, "R6 wrap to way 0");
    rd(32'h0000_2004, 1'b1, "R6 way 1 kept");
    rd(32'h0000_5004, 1'b1, "R6 new line hits");
    rd(32'h0000_1000, 1'b0, "R6 evicted line misses");
    rd(32'h0000_1000, 1'b1, "R10 re-allocated tag reads back once");
    rd(32'h0000_3008, 1'b1, "R6 way 2 kept");
    rd(32'h0000_2000, 1'b0, "R6 way 1 evicted");
    rd(32'h0000_1018, 1'b1, "R6 other segment untouched");

    // R9 invalidate-all
    @(negedge clk);
    inv_all = 1'b1;
    #1 check(req_ready == 1'b0, "R9", "req_ready during flush", 32'(req_ready), 32'd0);
    @(negedge clk);
    inv_all = 1'b0;
    rd(32'h0000_1018, 1'b0, "R9 segment 1 line gone");
    rd(32'h0000_5000, 1'b0, "R9 segment 0 line gone");

    repeat (4) @(negedge clk);
    check(q_hit.size() == 0, "R4", "responses outstanding", 32'(q_hit.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule